// File: doc/BRIEF.md
# Strap-Sampled Link Speed Latch

The block sets the serial link speed code for a device when it comes out of reset. Two strap inputs carry the requested speed. Each time reset is released, the block watches the straps through a stability window. When the straps have held the same value for a fixed number of consecutive clocks, it captures that value as the active speed. The active speed then stays put until the next reset, whatever the strap pins do.

Reset is released in one of two ways: the hard reset deasserts, or a self-reset-complete pulse arrives. Software can replace the active code at any time through a two-bit register write port, and the read port always returns the active code. A write made while the window is still open takes effect at once and cancels the pending capture. A self-reset-complete pulse throws away any software override and opens a fresh window.

The outputs are:
- the raw code;
- a one-hot rate indication;
- a flag that marks the code as settled;
- a flag for the illegal code.

Top module: `strap_speed_latch`

## Requirements
- R1: While `rst_ni` is low, `speed_o` = 2'b10, `rate_onehot_o` = 3'b100, `valid_o` = 0 and `illegal_o` = 0.
- R2: `rate_onehot_o` bit 0 marks code 2'b00 (1.25 Gbps), bit 1 marks code 2'b01 (2.5 Gbps) and bit 2 marks code 2'b10 (3.125 Gbps). Exactly one bit is high at all times.
- R3: While the window is open, the strap value is sampled on every rising edge. On the tenth consecutive edge that sees the same value, that value is loaded into `speed_o` and `valid_o` goes high. Both change at that edge.
- R4: When the straps differ from the previous sample during the window, that edge becomes the first of a new run of ten.
- R5: Once the window has closed, strap changes leave `speed_o` unchanged.
- R6: `reg_we_i` high at an edge loads `reg_wdata_i` into `speed_o` and sets `valid_o` at that edge. `reg_rdata_o` always equals `speed_o`.
- R7: A write made while the window is open closes the window, so no strap capture follows.
- R8: Code 2'b11 drives `illegal_o` high and `rate_onehot_o` to 3'b100, while `speed_o` and `reg_rdata_o` stay 2'b11.
- R9: `self_rst_done_i` high at an edge does three things at that edge:
  - it clears `valid_o`;
  - it sets `speed_o` to 2'b10;
  - it reopens the window.
  It takes priority over a write at the same edge.
- R10: A write at the same edge as a strap capture wins, and `speed_o` takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| self_rst_done_i | input | 1 | Self-reset completion pulse; re-arms sampling |
| strap_i | input | 2 | Speed strap inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 2 | Register write data, speed code |
| reg_rdata_o | output | 2 | Register read data, active speed code |
| speed_o | output | 2 | Active speed code |
| rate_onehot_o | output | 3 | Decoded one-hot rate |
| valid_o | output | 1 | Active code settled by capture or write |
| illegal_o | output | 1 | Active code is 2'b11 |

## Verification
Two pairs of events can fall on the same clock edge:
- a software write on the edge where the tenth stable strap sample would be captured;
- a self-reset-complete pulse together with a write.

The bench places both collisions on exact edges with directed sequences. It also scatters writes, pulses and strap changes at random, so that further coincidences occur. Each result is judged against a reference model with the priority order self-reset, then write, then capture. The written value must win over the strap value, and the re-arm must discard the write.

// File: rtl/strap_speed_pkg.sv
package strap_speed_pkg;
  localparam int CODE_W = 2;
  localparam int RATE_N = 3;

  typedef enum logic [CODE_W-1:0] {
    SPD_1G25  = 2'b00,
    SPD_2G5   = 2'b01,
    SPD_3G125 = 2'b10,
    SPD_BAD   = 2'b11
  } spd_code_e;

  localparam logic [CODE_W-1:0] SPD_DEFAULT = SPD_3G125;
endpackage

// File: rtl/strap_window.sv
module strap_window
  import strap_speed_pkg::*;
#(
  parameter int STABLE_CYCLES = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rearm_i,
  input  logic              cancel_i,
  input  logic [CODE_W-1:0] strap_i,
  output logic              armed_o,
  output logic              capture_o,
  output logic [CODE_W-1:0] cap_code_o
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);

  logic              armed_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] strap_q;
  logic              same;

  assign same       = (strap_i == strap_q);
  assign capture_o  = armed_q && (cnt_q == LAST) && same;
  assign cap_code_o = strap_i;
  assign armed_o    = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
      strap_q <= '0;
    end else if (rearm_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (cancel_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (cnt_q == '0 || !same) begin
        strap_q <= strap_i;
        cnt_q   <= CNT_W'(1);
      end else if (cnt_q == LAST) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !rearm_i && !cancel_i && cnt_q != '0 && !same) |=> cnt_q == CNT_W'(1));
  assert_closed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_i && !rearm_i) |=> !armed_q);
endmodule

// File: rtl/speed_hold.sv
module speed_hold
  import strap_speed_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rearm_i,
  input  logic              we_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [CODE_W-1:0] cap_code_i,
  output logic [CODE_W-1:0] speed_o,
  output logic              valid_o
);
  logic [CODE_W-1:0] speed_q;
  logic              valid_q;

  // priority: re-arm, then software, then strap capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      speed_q <= SPD_DEFAULT;
      valid_q <= 1'b0;
    end else if (rearm_i) begin
      speed_q <= SPD_DEFAULT;
      valid_q <= 1'b0;
    end else if (we_i) begin
      speed_q <= wdata_i;
      valid_q <= 1'b1;
    end else if (capture_i) begin
      speed_q <= cap_code_i;
      valid_q <= 1'b1;
    end
  end

  assign speed_o = speed_q;
  assign valid_o = valid_q;

  assert_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !rearm_i) |=> (speed_q == $past(wdata_i)) && valid_q);
  assert_rearm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> !valid_q && speed_q == SPD_DEFAULT);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rearm_i && !we_i && !capture_i) |=> $stable(speed_q) && $stable(valid_q));
endmodule

// File: rtl/speed_decode.sv
module speed_decode
  import strap_speed_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [RATE_N-1:0] rate_o,
  output logic              illegal_o
);
  assign illegal_o = (code_i == SPD_BAD);

  for (genvar i = 0; i < RATE_N; i++) begin : g_rate
    if (CODE_W'(i) == SPD_DEFAULT) begin : g_dflt
      assign rate_o[i] = (code_i == CODE_W'(i)) || illegal_o;
    end else begin : g_norm
      assign rate_o[i] = (code_i == CODE_W'(i));
    end
  end
endmodule

// File: rtl/strap_speed_latch.sv
module strap_speed_latch
  import strap_speed_pkg::*;
#(
  parameter int STABLE_CYCLES = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        self_rst_done_i,
  input  logic [1:0]  strap_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_wdata_i,
  output logic [1:0]  reg_rdata_o,
  output logic [1:0]  speed_o,
  output logic [2:0]  rate_onehot_o,
  output logic        valid_o,
  output logic        illegal_o
);
  logic              armed;
  logic              capture;
  logic [CODE_W-1:0] cap_code;
  logic [CODE_W-1:0] speed;

  strap_window #(.STABLE_CYCLES(STABLE_CYCLES)) u_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rearm_i    (self_rst_done_i),
    .cancel_i   (reg_we_i),
    .strap_i    (strap_i),
    .armed_o    (armed),
    .capture_o  (capture),
    .cap_code_o (cap_code)
  );

  speed_hold u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rearm_i    (self_rst_done_i),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .capture_i  (capture),
    .cap_code_i (cap_code),
    .speed_o    (speed),
    .valid_o    (valid_o)
  );

  speed_decode u_dec (
    .code_i    (speed),
    .rate_o    (rate_onehot_o),
    .illegal_o (illegal_o)
  );

  assign speed_o     = speed;
  assign reg_rdata_o = speed;

  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rate_onehot_o) == 1);
  assert_illegal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> rate_onehot_o == 3'b100 && reg_rdata_o == 2'b11);
  assert_ignore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !self_rst_done_i && !reg_we_i) |=> $stable(speed_o));
  assert_settled_closed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !armed);
endmodule

// File: tb/strap_speed_latch_test.sv
module strap_speed_latch_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srd = 1'b0;
  logic [1:0] strap = 2'b00;
  logic       we = 1'b0;
  logic [1:0] wd = 2'b00;
  logic [1:0] rdata, speed;
  logic [2:0] rate;
  logic       valid, illegal;

  int checks = 0;
  int errors = 0;

  // reference model
  bit       m_armed;
  int       m_cnt;
  logic [1:0] m_q, m_speed;
  bit       m_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_speed_latch #(.STABLE_CYCLES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .self_rst_done_i(srd), .strap_i(strap),
    .reg_we_i(we), .reg_wdata_i(wd), .reg_rdata_o(rdata), .speed_o(speed),
    .rate_onehot_o(rate), .valid_o(valid), .illegal_o(illegal)
  );

  function automatic logic [2:0] exp_rate(logic [1:0] c);
    case (c)
      2'b00: return 3'b001;
      2'b01: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_armed = 1; m_cnt = 0; m_q = 2'b00; m_speed = 2'b10; m_valid = 0;
  endtask

  task automatic model_step();
    if (srd) begin
      m_armed = 1; m_cnt = 0; m_speed = 2'b10; m_valid = 0;
    end else if (we) begin
      m_speed = wd; m_valid = 1; m_armed = 0; m_cnt = 0;
    end else if (m_armed) begin
      if (m_cnt == 0 || strap != m_q) begin
        m_q = strap; m_cnt = 1;
      end else if (m_cnt == N-1) begin
        m_speed = strap; m_valid = 1; m_armed = 0; m_cnt = 0;
      end else m_cnt++;
    end
  endtask

  task automatic cmp_model(string req);
    chk(req, "speed", speed, m_speed);
    chk(req, "rdata", rdata, m_speed);
    chk(req, "valid", valid, m_valid);
    chk(req, "rate", rate, exp_rate(m_speed));
    chk(req, "illegal", illegal, m_speed == 2'b11);
  endtask

  // drive at negedge, one edge, compare at next negedge
  task automatic tick(string req, bit s, logic [1:0] st, bit w, logic [1:0] d);
    srd = s; strap = st; we = w; wd = d;
    model_step();
    @(negedge clk);
    srd = 0; we = 0;
    cmp_model(req);
  endtask

  task automatic idle(string req, int n, logic [1:0] st);
    for (int i = 0; i < n; i++) tick(req, 0, st, 0, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5821));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "speed", speed, 2); chk("R1", "valid", valid, 0);
    chk("R1", "rate", rate, 3'b100); chk("R1", "illegal", illegal, 0);
    strap = 2'b00;
    rst_n = 1'b1;
    // R3: nine edges, still not captured
    idle("R3", N-1, 2'b00);
    chk("R3", "valid before 10th", valid, 0);
    tick("R3", 0, 2'b00, 0, 2'b00);
    chk("R3", "captured", speed, 0); chk("R2", "rate 1.25", rate, 3'b001);
    chk("R3", "valid", valid, 1);
    // R5 straps ignored after capture
    idle("R5", 4, 2'b01);
    chk("R5", "speed held", speed, 0);
    // R6 write and R2 decode
    tick("R6", 0, 2'b11, 1, 2'b01);
    chk("R6", "rdata", rdata, 1); chk("R2", "rate 2.5", rate, 3'b010);
    // R8 illegal
    tick("R8", 0, 2'b11, 1, 2'b11);
    chk("R8", "illegal", illegal, 1); chk("R8", "rate", rate, 3'b100);
    chk("R8", "rdata", rdata, 3);
    // R9 self-reset, then R4 restart on strap change
    tick("R9", 1, 2'b01, 0, 2'b00);
    chk("R9", "valid", valid, 0); chk("R9", "speed", speed, 2);
    idle("R4", 5, 2'b01);
    idle("R4", N-1, 2'b00);
    chk("R4", "not yet", valid, 0);
    tick("R4", 0, 2'b00, 0, 2'b00);
    chk("R4", "captured", speed, 0); chk("R4", "valid", valid, 1);
    // R7 write in window cancels capture
    tick("R9", 1, 2'b01, 0, 2'b00);
    idle("R7", 3, 2'b01);
    tick("R7", 0, 2'b01, 1, 2'b00);
    idle("R7", 2*N, 2'b01);
    chk("R7", "no capture", speed, 0);
    // R10 write on capture edge
    tick("R9", 1, 2'b01, 0, 2'b00);
    idle("R10", N-1, 2'b01);
    tick("R10", 0, 2'b01, 1, 2'b00);
    chk("R10", "write wins", speed, 0);
    // R9 self-reset beats same-edge write
    tick("R9", 1, 2'b00, 1, 2'b01);
    chk("R9", "pulse wins", speed, 2); chk("R9", "valid", valid, 0);
    idle("R9", N, 2'b01);
    chk("R9", "fresh capture", speed, 1);
    // R1 hard reset mid-run
    @(negedge clk);
    rst_n = 1'b0; model_reset();
    #1;
    chk("R1", "speed", speed, 2); chk("R1", "valid", valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R3", N, 2'b10);
    chk("R3", "capture 3.125", speed, 2); chk("R3", "valid", valid, 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] st;
      bit s, w;
      st = ($urandom_range(0, 7) == 0) ? 2'($urandom) : strap;
      s  = ($urandom_range(0, 60) == 0);
      w  = ($urandom_range(0, 40) == 0);
      tick("R5", s, st, w, 2'($urandom));
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule